// File: doc/BRIEF.md
# IDE Host Register Bridge

This block is a memory-mapped slave placed between a 32-bit system bus and the register port of an IDE/ATA drive interface. It decodes a 4 KB window in which registers sit on a 16-byte stride. The register index is the byte address shifted right by four. The access size is taken from the byte enables, and every register accepts only certain sizes. An access with the wrong size is dropped: a read of it returns all ones and a write of it changes nothing.

Legal data-port, taskfile and status/command accesses go on to a simple drive-side register port in the same cycle. The bridge itself holds a 32-bit timing register and a 32-bit interrupt state register. The interrupt state register tracks a DMA interrupt line and a disk interrupt line. Software can clear the DMA bit by writing a one to it. Each interrupt line is also passed straight through to its own output pin.

The bus accepts a request in every cycle. Read data is returned one clock after the request, and byte lanes keep little-endian order, unchanged from the bus.

Top module: `ide_reg_bridge`

## Requirements
- R1: The register index is `bus_addr[11:4]`. Address bits 3:0 do not affect the decode.
- R2: The access size comes from `bus_be`.
  - 0001, 0010, 0100 and 1000 are byte accesses.
  - 0011 and 1100 are 16-bit accesses.
  - 1111 is a 32-bit access.
  - Every other pattern is illegal for all registers.
- R3: Index 0 is the data port and accepts only 16-bit and 32-bit accesses. A legal access is forwarded with `drv_reg` = 0. A byte access is not forwarded.
- R4: Indices 1 to 7 are taskfile registers and accept only byte accesses. A legal access is forwarded with `drv_reg` equal to the index.
- R5: Indices 0x08 and 0x16 both reach status/command, byte accesses only. They are forwarded with `drv_reg` = 8: a read returns status and a write issues a command.
- R6: Index 0x20 is the timing register. It accepts only 32-bit accesses, reads back the last value written and resets to 0.
- R7: Index 0x30 is the interrupt state register. It accepts only 32-bit reads and resets to 0.
  - Bit 31 is the DMA interrupt.
  - Bit 30 is the disk interrupt.
  - Bits 29:0 always read 0.
- R8: Bit 31 follows the DMA line's edges:
  - A rising edge of `dma_irq_in` sets it.
  - A falling edge clears it.
  - Otherwise, a 32-bit write to index 0x30 with data bit 31 set clears it.
  - A rising edge takes priority over a clear write in the same cycle.
  - A write to index 0x30 with bit 31 clear has no effect.
- R9: Bit 30 equals the level `disk_irq_in` had one clock earlier.
- R10: `dma_irq_out` equals `dma_irq_in` and `disk_irq_out` equals `disk_irq_in`, with no register between them.
- R11: A read of an unmapped index or with an illegal size returns 0xFFFFFFFF. A write under the same conditions reaches neither the drive port nor any register.
- R12: `bus_ready` is always 1. `bus_rvalid` pulses one clock after each read request, with the read data, and stays 0 after writes. `drv_rdata` is sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_be | input | 4 | Byte enables (access size) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| drv_valid | output | 1 | Drive-port access strobe |
| drv_write | output | 1 | Drive-port write |
| drv_reg | output | 4 | Drive register number (0 data, 1-7 taskfile, 8 status/command) |
| drv_be | output | 4 | Byte enables to drive |
| drv_wdata | output | 32 | Write data to drive |
| drv_rdata | input | 32 | Read data from drive, same cycle |
| dma_irq_in | input | 1 | DMA interrupt line |
| disk_irq_in | input | 1 | Disk interrupt line |
| dma_irq_out | output | 1 | DMA interrupt output |
| disk_irq_out | output | 1 | Disk interrupt output |

## Verification
The decode is exercised with random accesses drawn from every mapped index and from random unmapped indices. These accesses use random low address bits and all sixteen byte-enable patterns. This mix separates a register that is correctly forwarded or held from one that takes a size it should refuse, or that leaks a write it should drop.

Directed sequences cover the interrupt edge cases:
- A rise of the DMA line, a clear write while the line stays high, the line falling, and a second rise.
- A write with bit 31 clear.
- Disk-line toggles.
- A clear write in the same cycle as a rise.

These show whether bit 31 is edge-driven and whether a clear sticks. Reads right after reset and after each write show the reset values and that timing data is retained.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

  typedef enum logic [1:0] {SZ_BAD, SZ_8, SZ_16, SZ_32} acc_size_e;
  typedef enum logic [2:0] {T_NONE, T_DATA, T_TASK, T_STAT, T_TIMING, T_IRQ} target_e;

  localparam int unsigned IDX_DATA   = 'h00;
  localparam int unsigned IDX_TF_LO  = 'h01;
  localparam int unsigned IDX_TF_HI  = 'h07;
  localparam int unsigned IDX_STAT_A = 'h08;
  localparam int unsigned IDX_STAT_B = 'h16;
  localparam int unsigned IDX_TIMING = 'h20;
  localparam int unsigned IDX_IRQ    = 'h30;

  localparam logic [3:0] DRV_REG_DATA = 4'd0;
  localparam logic [3:0] DRV_REG_STAT = 4'd8;

  localparam int unsigned LINE_DMA  = 0;
  localparam int unsigned LINE_DISK = 1;

  // Access size from the byte-enable pattern
  function automatic acc_size_e size_of_be(input logic [3:0] be);
    case (be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000: size_of_be = SZ_8;
      4'b0011, 4'b1100:                   size_of_be = SZ_16;
      4'b1111:                            size_of_be = SZ_32;
      default:                            size_of_be = SZ_BAD;
    endcase
  endfunction

  // Interrupt state bit position for a given interrupt line
  function automatic int unsigned irq_bit_of(input int unsigned line);
    irq_bit_of = 31 - line;
  endfunction

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_SHIFT = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output target_e           tgt,
  output logic [3:0]        drv_reg,
  output acc_size_e         size
);
  localparam int unsigned IDX_W = ADDR_W - IDX_SHIFT;

  logic [IDX_W-1:0] idx;
  logic is_data, is_tf, is_stat, is_tim, is_irq;

  assign idx  = addr[ADDR_W-1:IDX_SHIFT];
  assign size = size_of_be(be);

  assign is_data = (idx == IDX_W'(IDX_DATA));
  assign is_tf   = (idx >= IDX_W'(IDX_TF_LO)) && (idx <= IDX_W'(IDX_TF_HI));
  assign is_stat = (idx == IDX_W'(IDX_STAT_A)) || (idx == IDX_W'(IDX_STAT_B));
  assign is_tim  = (idx == IDX_W'(IDX_TIMING));
  assign is_irq  = (idx == IDX_W'(IDX_IRQ));

  always_comb begin
    tgt     = T_NONE;
    drv_reg = DRV_REG_DATA;
    if (is_data && (size == SZ_16 || size == SZ_32)) begin
      tgt = T_DATA;
    end else if (is_tf && size == SZ_8) begin
      tgt     = T_TASK;
      drv_reg = 4'(idx);
    end else if (is_stat && size == SZ_8) begin
      tgt     = T_STAT;
      drv_reg = DRV_REG_STAT;
    end else if (is_tim && size == SZ_32) begin
      tgt = T_TIMING;
    end else if (is_irq && size == SZ_32) begin
      tgt = T_IRQ;
    end
  end

  // R2: an illegal byte-enable pattern never selects a register
  always_comb begin
    if (size == SZ_BAD) p_bad_size_unmapped_r2: assert (tgt == T_NONE);
  end

endmodule

// File: rtl/ide_irq_state.sv
module ide_irq_state
  import ide_bridge_pkg::*;
#(
  parameter int unsigned  N_LINES  = 2,
  parameter logic [N_LINES-1:0] CLR_MASK = 'b01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               clr_req,
  input  logic [31:0]        clr_data,
  output logic [31:0]        state,
  output logic [N_LINES-1:0] irq_out
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] rise, fall, wclr;

  assign irq_out = irq_in;
  assign state[31-N_LINES:0] = '0;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    localparam int unsigned B = 31 - n;
    assign rise[n] = irq_in[n] & ~prev_q[n];
    assign fall[n] = ~irq_in[n] & prev_q[n];
    assign wclr[n] = clr_req & CLR_MASK[n] & clr_data[B];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[n] <= 1'b0;
        state[B]  <= 1'b0;
      end else begin
        prev_q[n] <= irq_in[n];
        if (rise[n])      state[B] <= 1'b1;
        else if (fall[n]) state[B] <= 1'b0;
        else if (wclr[n]) state[B] <= 1'b0;
      end
    end
  end

  localparam int unsigned DMA_B  = 31 - LINE_DMA;
  localparam int unsigned DISK_B = 31 - LINE_DISK;

  // R8: rise sets the DMA bit even with a clear in the same cycle
  p_dma_rise_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise[LINE_DMA] |=> state[DMA_B]);
  // R8: a clear write with no DMA edge leaves the bit low
  p_dma_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr[LINE_DMA] && !rise[LINE_DMA]) |=> !state[DMA_B]);
  // R9: disk bit tracks the previous level of the disk line
  p_disk_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> state[DISK_B] == $past(irq_in[LINE_DISK]));

endmodule

// File: rtl/ide_reg_bridge.sv
module ide_reg_bridge
  import ide_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              drv_valid,
  output logic              drv_write,
  output logic [3:0]        drv_reg,
  output logic [3:0]        drv_be,
  output logic [31:0]       drv_wdata,
  input  logic [31:0]       drv_rdata,
  input  logic              dma_irq_in,
  input  logic              disk_irq_in,
  output logic              dma_irq_out,
  output logic              disk_irq_out
);
  target_e     tgt;
  acc_size_e   size;
  logic [3:0]  dec_reg;
  logic [31:0] timing_q, irq_state, rd_next, rdata_q;
  logic        rvalid_q, wr_fire, rd_fire, timing_we, irq_clr;
  logic [1:0]  irq_lines_in, irq_lines_out;

  ide_addr_decode #(.ADDR_W(ADDR_W), .IDX_SHIFT(IDX_SHIFT)) i_dec (
    .addr(bus_addr), .be(bus_be), .tgt(tgt), .drv_reg(dec_reg), .size(size)
  );

  assign wr_fire   = bus_valid & bus_write;
  assign rd_fire   = bus_valid & ~bus_write;
  assign timing_we = wr_fire & (tgt == T_TIMING);
  assign irq_clr   = wr_fire & (tgt == T_IRQ);

  assign irq_lines_in = {disk_irq_in, dma_irq_in};

  ide_irq_state #(.N_LINES(2), .CLR_MASK(2'b01)) i_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_lines_in), .clr_req(irq_clr),
    .clr_data(bus_wdata), .state(irq_state), .irq_out(irq_lines_out)
  );
  assign dma_irq_out  = irq_lines_out[LINE_DMA];
  assign disk_irq_out = irq_lines_out[LINE_DISK];

  assign drv_valid = bus_valid & (tgt == T_DATA || tgt == T_TASK || tgt == T_STAT);
  assign drv_write = bus_write;
  assign drv_reg   = dec_reg;
  assign drv_be    = bus_be;
  assign drv_wdata = bus_wdata;
  assign bus_ready = 1'b1;

  always_comb begin
    case (tgt)
      T_DATA, T_TASK, T_STAT: rd_next = drv_rdata;
      T_TIMING:               rd_next = timing_q;
      T_IRQ:                  rd_next = irq_state;
      default:                rd_next = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (timing_we) timing_q <= bus_wdata;
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rd_next;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  // R12: one read-data pulse per read request, none after writes
  p_rvalid_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> bus_rvalid);
  p_no_rvalid_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !bus_rvalid);
  // R11: unmapped or wrong-size read returns all ones
  p_unmapped_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && tgt == T_NONE) |=> bus_rdata == 32'hFFFF_FFFF);
  // R11: a dropped access never reaches the drive
  p_dropped_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && tgt == T_NONE) |-> !drv_valid);
  // R6: timing register only moves on a legal timing write
  p_timing_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_we |=> $stable(timing_q));
  // R7: low interrupt-state bits stay zero
  p_irq_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_state[29:0] == 30'd0);

endmodule

// File: tb/test_ide_reg_bridge.sv
module test_ide_reg_bridge;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, bus_rvalid, drv_valid, drv_write;
  logic [31:0] bus_rdata, drv_wdata, drv_rdata;
  logic [3:0] drv_reg, drv_be;
  logic dma_in = 0, disk_in = 0, dma_out, disk_out;

  int n_checks = 0, n_fail = 0;
  logic [31:0] m_timing = 0;
  logic m_dma = 0, m_disk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // drive-side model: value depends on the selected register
  function automatic logic [31:0] drv_val(input logic [3:0] r);
    return {4'hD, r, 8'h5A, 4'h3, r, 8'hC3};
  endfunction
  assign drv_rdata = drv_val(drv_reg);

  ide_reg_bridge i_ide_reg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .drv_valid(drv_valid), .drv_write(drv_write), .drv_reg(drv_reg),
    .drv_be(drv_be), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .dma_irq_in(dma_in), .disk_irq_in(disk_in),
    .dma_irq_out(dma_out), .disk_irq_out(disk_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // kind: 0 dropped, 1 drive, 2 timing, 3 irq ; dreg = drive register
  function automatic int kind_of(input logic [11:0] a, input logic [3:0] be,
                                 output logic [3:0] dreg);
    int idx = int'(a >> 4);
    int ones = $countones(be);
    bit b8  = (ones == 1);
    bit b16 = (be == 4'h3) || (be == 4'hC);
    bit b32 = (be == 4'hF);
    dreg = 0;
    if (idx == 0 && (b16 || b32)) return 1;
    if (idx >= 1 && idx <= 7 && b8) begin dreg = 4'(idx); return 1; end
    if ((idx == 8 || idx == 22) && b8) begin dreg = 8; return 1; end
    if (idx == 32 && b32) return 2;
    if (idx == 48 && b32) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] irq_model();
    return {m_dma, m_disk, 30'd0};
  endfunction

  task automatic access(input bit wr, input logic [11:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input string req);
    logic [3:0] dreg;
    int k;
    logic [31:0] exp;
    k = kind_of(a, be, dreg);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    #1;
    check({req, " drv_valid"}, 32'(drv_valid), 32'(k == 1));
    if (k == 1) begin
      check({req, " drv_reg"}, 32'(drv_reg), 32'(dreg));
      check({req, " drv_write"}, 32'(drv_write), 32'(wr));
      if (wr) check({req, " drv_wdata"}, drv_wdata, wd);
    end
    case (k)
      1: exp = drv_val(dreg);
      2: exp = m_timing;
      3: exp = irq_model();
      default: exp = 32'hFFFF_FFFF;
    endcase
    if (wr && k == 2) m_timing = wd;
    if (wr && k == 3 && wd[31]) m_dma = 0;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check({req, " R12 rvalid"}, 32'(bus_rvalid), 32'(!wr));
    if (!wr) check({req, " rdata"}, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] bes [0:15];
    int idxs [0:11] = '{0,1,2,3,7,8,22,32,48,9,23,255};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 reset rvalid", 32'(bus_rvalid), 0);
    check("R12 ready", 32'(bus_ready), 1);
    access(0, 12'h200, 4'hF, 0, "R6 timing reset");
    access(0, 12'h300, 4'hF, 0, "R7 irq reset");

    // directed decode cases
    access(1, 12'h200, 4'hF, 32'hCAFE_0123, "R6 timing write");
    access(0, 12'h20C, 4'hF, 0, "R1 R6 low bits ignored");
    access(1, 12'h200, 4'h3, 32'h1111_1111, "R6 R11 16-bit write dropped");
    access(0, 12'h200, 4'h1, 0, "R6 R11 byte read ones");
    access(0, 12'h000, 4'h3, 0, "R3 data 16");
    access(1, 12'h004, 4'hF, 32'h1234_5678, "R3 data 32 write");
    access(0, 12'h000, 4'h1, 0, "R3 data byte dropped");
    access(1, 12'h070, 4'h1, 32'h0000_00EC, "R4 taskfile 7 write");
    access(0, 12'h030, 4'h4, 0, "R4 taskfile 3 read");
    access(0, 12'h010, 4'hF, 0, "R4 taskfile 32 dropped");
    access(0, 12'h080, 4'h1, 0, "R5 status read 0x08");
    access(1, 12'h160, 4'h1, 32'h0000_00EF, "R5 command 0x16");
    access(0, 12'h090, 4'h1, 0, "R11 unmapped");
    access(0, 12'h000, 4'h5, 0, "R2 illegal be");

    // interrupt sequences
    @(negedge clk); dma_in = 1; #1;
    check("R10 dma out", 32'(dma_out), 1);
    m_dma = 1;
    access(0, 12'h300, 4'hF, 0, "R8 dma rise");
    access(1, 12'h300, 4'hF, 32'h4000_0000, "R8 write no bit31");
    access(0, 12'h300, 4'hF, 0, "R8 no effect");
    access(1, 12'h300, 4'hF, 32'h8000_0000, "R8 clear");
    access(0, 12'h300, 4'hF, 0, "R8 cleared while high");
    access(1, 12'h300, 4'h3, 32'h8000_0000, "R8 R11 16-bit clear dropped");
    @(negedge clk); dma_in = 0; disk_in = 1; #1;
    check("R10 disk out", 32'(disk_out), 1);
    check("R10 dma out low", 32'(dma_out), 0);
    m_disk = 1;
    access(0, 12'h300, 4'hF, 0, "R8 R9 fall and disk");
    // rise and clear in the same cycle: rise wins
    @(negedge clk);
    dma_in = 1;
    bus_valid = 1; bus_write = 1; bus_addr = 12'h300; bus_be = 4'hF; bus_wdata = 32'h8000_0000;
    @(negedge clk); bus_valid = 0; bus_write = 0;
    m_dma = 1;
    access(0, 12'h300, 4'hF, 0, "R8 rise beats clear");
    @(negedge clk); dma_in = 0; m_dma = 0; disk_in = 0; m_disk = 0;
    access(0, 12'h300, 4'hF, 0, "R8 R9 both low");

    // constrained random decode traffic (R1 R2 R3 R4 R5 R6 R11)
    for (int i = 0; i < 16; i++) bes[i] = 4'(i);
    for (int i = 0; i < 400; i++) begin
      int ix;
      logic [11:0] a;
      ix = idxs[$urandom_range(11)];
      if (ix == 255) ix = 64 + $urandom_range(191);
      a = {8'(ix), 4'($urandom_range(15))};
      access(1'($urandom_range(1)), a, bes[$urandom_range(15)], $urandom, "R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule